// File: doc/BRIEF.md
# Multimode Serial Port with Address Filtering

This block is a byte-register serial port for a microcontroller subsystem. Software selects one of four framings through a control register. Mode 0 is a synchronous 8-bit shifter with its own shift clock. Mode 1 is an 8-bit asynchronous frame. Modes 2 and 3 are 9-bit asynchronous frames. Modes 1 and 3 take their 16x oversampling tick from an external baud tick. Mode 2 derives its tick from the oscillator clock, which gives either 32 or 16 clocks per bit.

In the 9-bit modes the receiver can act as a multiprocessor node. When the address-recognition bit is set, a frame is accepted only when its ninth bit is 1 and its byte matches the node's masked address or its broadcast address. Software clears the recognition bit once an address frame has been accepted, so that the data frames that follow are received. A data write starts a transmission. A data read returns a separate receive buffer. The transmit and receive flags drive the two interrupt outputs.

Top module: `mp_serial_port`

## Requirements
- R1: After reset all four registers read 0, txd_out and sclk_out are high, and both interrupt outputs are low.
- R2: Register select 0 is the control register, 2 is the own-address register and 3 is the address-mask register. All three read back what was written. Control bits 7:6 hold the mode number (bit 7 is the high bit). Bit 5 is address recognition, bit 4 is receive enable, bit 3 is the transmit ninth bit, bit 2 is the received ninth bit, bit 1 is the transmit flag and bit 0 is the receive flag.
- R3: Register select 1 is the data buffer. A write loads and starts the transmitter. A read returns the last accepted received byte, whatever byte was last written.
- R4: In mode 0, each bit lasts 4 clocks, with sclk_out low for the first 2 and high for the last 2. The transmitter shifts 8 bits out on txd_out, LSB first, and sets the transmit flag after the 8th bit. The receiver starts when receive enable is 1 and the receive flag is 0. It samples rxd_in while sclk_out is high, sets the receive flag after 8 bits and leaves control bit 2 unchanged.
- R5: In mode 1, a transmit frame is a 0 start bit, 8 data bits LSB first and a 1 stop bit. Each bit lasts 16 baud ticks. The transmit flag is set when the stop bit starts.
- R6: In mode 1, control bit 2 takes the received stop bit. With address recognition set, a frame whose stop bit is 0 is discarded.
- R7: In modes 2 and 3, a frame carries a ninth bit between the data and the stop bit. It is sent from control bit 3 and stored into control bit 2 on receive. Mode 2 bits last 32 clocks when m2_fast is 0 and 16 clocks when it is 1.
- R8: In modes 2 and 3 with address recognition set, a frame is accepted only if its ninth bit is 1 and either (byte & mask) == (own & mask) or (byte & (own | mask)) == (own | mask). With the mask at 0, every byte matches.
- R9: With receive enable at 0, no frame is received: the receive flag and the buffer stay unchanged.
- R10: Both flags are set only by hardware and stay set until a control write clears them.
- R11: A start bit whose majority vote over oversampling samples 7, 8 and 9 is high is treated as noise and does not produce a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | 16x oversampling tick for modes 1 and 3 |
| m2_fast | input | 1 | Mode 2 rate select: 1 gives 16 clocks per bit, 0 gives 32 |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| rxd_in | input | 1 | Serial receive line |
| txd_out | output | 1 | Serial transmit line; mode 0 data out |
| sclk_out | output | 1 | Mode 0 shift clock, high when idle |
| tx_irq | output | 1 | Transmit flag |
| rx_irq | output | 1 | Receive flag |

## Verification
A register write takes effect one clock later. A transmit line drops the clock after the data write. The transmit flag rises one clock after the stop bit begins, or about two clocks after the last mode-0 shift-clock rise. The receive flag rises about ten oversampling ticks into the stop bit. For that reason the bench samples each transmitted bit at its centre, measured from the observed start edge. It checks the transmit flag at the centres of the last data bit and of the stop bit. It reads the receive flag and buffer only after a full idle bit has followed each driven frame, so the checks do not depend on the exact tick phase.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT = 2'b00,
    MODE_U8    = 2'b01,
    MODE_U9F   = 2'b10,
    MODE_U9V   = 2'b11
  } sp_mode_e;

  localparam int DATA_W = 8;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_OWN  = 2'd2;
  localparam logic [1:0] SEL_MASK = 2'd3;

  localparam int B_AEN = 5;
  localparam int B_REN = 4;
  localparam int B_TB9 = 3;
  localparam int B_RB9 = 2;
  localparam int B_TXF = 1;
  localparam int B_RXF = 0;

  function automatic logic addr_hit(input logic [DATA_W-1:0] rx_byte,
                                    input logic [DATA_W-1:0] own,
                                    input logic [DATA_W-1:0] mask);
    logic [DATA_W-1:0] given;
    logic [DATA_W-1:0] bcast;
    given = own & mask;
    bcast = own | mask;
    return ((rx_byte & mask) == given) || ((rx_byte & bcast) == bcast);
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [3:0] frame_bits(input sp_mode_e m);
    return m[1] ? 4'd11 : 4'd10;
  endfunction
endpackage

// File: rtl/sp_tick_gen.sv
module sp_tick_gen import sp_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  sp_mode_e mode,
  input  logic     fast,
  input  logic     ext_tick,
  output logic     os_tick
);
  logic half_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  always_comb begin
    case (mode)
      MODE_U9F:         os_tick = fast ? 1'b1 : half_q;
      MODE_U8, MODE_U9V: os_tick = ext_tick;
      default:          os_tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/sp_tx.sv
module sp_tx import sp_pkg::*; #(
  parameter int OS_RATE = 16,
  parameter int M0_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sp_mode_e          mode,
  input  logic              os_tick,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic              bit9,
  output logic              txd,
  output logic              sclk,
  output logic              busy,
  output logic              done
);
  localparam int SW = $clog2(OS_RATE);
  localparam logic [SW-1:0] S_END  = SW'(OS_RATE - 1);
  localparam logic [SW-1:0] M_END  = SW'(M0_DIV - 1);
  localparam logic [SW-1:0] M_HALF = SW'(M0_DIV / 2);

  logic          busy_q, m0_q, done_q;
  logic [10:0]   sh_q;
  logic [3:0]    left_q;
  logic [SW-1:0] sub_q;
  logic          step;

  assign step = busy_q && (m0_q ? (sub_q == M_END) : (os_tick && sub_q == S_END));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      m0_q   <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        sub_q  <= '0;
        m0_q   <= (mode == MODE_SHIFT);
        if (mode == MODE_SHIFT) begin
          sh_q   <= {3'b111, din};
          left_q <= 4'd8;
        end else begin
          sh_q   <= mode[1] ? {1'b1, bit9, din, 1'b0} : {2'b11, din, 1'b0};
          left_q <= frame_bits(mode);
        end
      end else if (busy_q) begin
        if (step) begin
          sub_q  <= '0;
          sh_q   <= {1'b1, sh_q[10:1]};
          left_q <= left_q - 4'd1;
          if (left_q == 4'd1) busy_q <= 1'b0;
          if (!m0_q && left_q == 4'd2) done_q <= 1'b1;
          if (m0_q && left_q == 4'd1)  done_q <= 1'b1;
        end else if (m0_q || os_tick) begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign sclk = (busy_q && m0_q) ? (sub_q >= M_HALF) : 1'b1;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/sp_rx.sv
module sp_rx import sp_pkg::*; #(
  parameter int OS_RATE = 16,
  parameter int M0_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sp_mode_e          mode,
  input  logic              os_tick,
  input  logic              rx_en,
  input  logic              rx_flag,
  input  logic              tx_busy,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              bit9,
  output logic              stop,
  output logic              busy,
  output logic              sclk
);
  localparam int SW = $clog2(OS_RATE);
  localparam logic [SW-1:0] S_LO   = SW'(OS_RATE / 2 - 1);
  localparam logic [SW-1:0] S_HI   = SW'(OS_RATE / 2 + 1);
  localparam logic [SW-1:0] S_END  = SW'(OS_RATE - 1);
  localparam logic [SW-1:0] M_END  = SW'(M0_DIV - 1);
  localparam logic [SW-1:0] M_HALF = SW'(M0_DIV / 2);

  logic              s1_q, s2_q;
  logic              busy_q, m0_q, done_q;
  logic [SW-1:0]     sub_q;
  logic [3:0]        idx_q;
  logic [1:0]        smp_q;
  logic [DATA_W-1:0] dat_q;
  logic              b9_q, stop_q;
  logic              vote;
  logic [3:0]        last_idx;

  assign vote     = vote3(smp_q[1], smp_q[0], s2_q);
  assign last_idx = frame_bits(mode) - 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      busy_q <= 1'b0;
      m0_q   <= 1'b0;
      done_q <= 1'b0;
      sub_q  <= '0;
      idx_q  <= '0;
      smp_q  <= '0;
      dat_q  <= '0;
      b9_q   <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      s1_q   <= rxd;
      s2_q   <= s1_q;
      done_q <= 1'b0;
      if (!busy_q) begin
        if (rx_en && mode == MODE_SHIFT && !rx_flag && !tx_busy && !done_q) begin
          busy_q <= 1'b1;
          m0_q   <= 1'b1;
          sub_q  <= '0;
          idx_q  <= '0;
        end else if (rx_en && mode != MODE_SHIFT && os_tick && !s2_q) begin
          busy_q <= 1'b1;
          m0_q   <= 1'b0;
          sub_q  <= SW'(1);
          idx_q  <= '0;
        end
      end else if (m0_q) begin
        if (sub_q == M_END) begin
          sub_q <= '0;
          dat_q <= {s2_q, dat_q[DATA_W-1:1]};
          idx_q <= idx_q + 4'd1;
          if (idx_q == 4'd7) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end else if (os_tick) begin
        if (sub_q == S_END) begin
          sub_q <= '0;
          idx_q <= idx_q + 4'd1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
        if (sub_q >= S_LO && sub_q < S_HI) smp_q <= {smp_q[0], s2_q};
        if (sub_q == S_HI) begin
          if (idx_q == 4'd0) begin
            if (vote) busy_q <= 1'b0;
          end else if (idx_q <= 4'd8) begin
            dat_q <= {vote, dat_q[DATA_W-1:1]};
          end else if (idx_q < last_idx) begin
            b9_q <= vote;
          end
          if (idx_q == last_idx) begin
            stop_q <= vote;
            done_q <= 1'b1;
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  assign done = done_q;
  assign data = dat_q;
  assign bit9 = b9_q;
  assign stop = stop_q;
  assign busy = busy_q;
  assign sclk = (busy_q && m0_q) ? (sub_q >= M_HALF) : 1'b1;
endmodule

// File: rtl/mp_serial_port.sv
module mp_serial_port import sp_pkg::*; #(
  parameter int OS_RATE = 16,
  parameter int M0_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              m2_fast,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rxd_in,
  output logic              txd_out,
  output logic              sclk_out,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic [DATA_W-1:0] ctrl_q, rxbuf_q, own_q, mask_q;
  sp_mode_e          mode;
  logic              os_tick;
  logic              wr_ctrl, tx_start;
  logic              tx_busy, tx_done, tx_sclk;
  logic              rx_done, rx_bit9, rx_stop, rx_busy, rx_sclk;
  logic [DATA_W-1:0] rx_data;
  logic              rx_accept, rb9_next, addr_en;

  assign mode     = sp_mode_e'(ctrl_q[7:6]);
  assign addr_en  = ctrl_q[B_AEN];
  assign wr_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
  assign tx_start = reg_wr && (reg_sel == SEL_DATA);

  sp_tick_gen u_tick (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fast(m2_fast),
    .ext_tick(baud_tick), .os_tick(os_tick)
  );

  sp_tx #(.OS_RATE(OS_RATE), .M0_DIV(M0_DIV)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick),
    .start(tx_start), .din(reg_wdata), .bit9(ctrl_q[B_TB9]),
    .txd(txd_out), .sclk(tx_sclk), .busy(tx_busy), .done(tx_done)
  );

  sp_rx #(.OS_RATE(OS_RATE), .M0_DIV(M0_DIV)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .os_tick(os_tick),
    .rx_en(ctrl_q[B_REN]), .rx_flag(ctrl_q[B_RXF]), .tx_busy(tx_busy),
    .rxd(rxd_in), .done(rx_done), .data(rx_data), .bit9(rx_bit9),
    .stop(rx_stop), .busy(rx_busy), .sclk(rx_sclk)
  );

  always_comb begin
    rx_accept = 1'b0;
    if (rx_done) begin
      case (mode)
        MODE_SHIFT: rx_accept = 1'b1;
        MODE_U8:    rx_accept = !addr_en || rx_stop;
        default:    rx_accept = !addr_en || (rx_bit9 && addr_hit(rx_data, own_q, mask_q));
      endcase
    end
  end

  assign rb9_next = (mode == MODE_U8) ? rx_stop : rx_bit9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      rxbuf_q <= '0;
      own_q   <= '0;
      mask_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata;
      if (tx_done) ctrl_q[B_TXF] <= 1'b1;
      if (rx_accept) begin
        ctrl_q[B_RXF] <= 1'b1;
        if (mode != MODE_SHIFT) ctrl_q[B_RB9] <= rb9_next;
        rxbuf_q <= rx_data;
      end
      if (reg_wr && reg_sel == SEL_OWN)  own_q  <= reg_wdata;
      if (reg_wr && reg_sel == SEL_MASK) mask_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_DATA: reg_rdata = rxbuf_q;
      SEL_OWN:  reg_rdata = own_q;
      default:  reg_rdata = mask_q;
    endcase
  end

  assign sclk_out = tx_sclk & rx_sclk;
  assign tx_irq   = ctrl_q[B_TXF];
  assign rx_irq   = ctrl_q[B_RXF];
endmodule

// File: rtl/mp_serial_port_chk.sv
module mp_serial_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_ctrl,
  input logic [7:0] ctrl_q,
  input logic       tx_done,
  input logic       tx_busy,
  input logic       txd_out,
  input logic       rx_accept,
  input logic       rx_busy,
  input logic       rx_bit9,
  input logic       rx_stop
);
  // R5: a transmit flag rise not caused by software follows a transmitter stop-bit event
  a_r5_tx_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctrl_q[1]) && !$past(wr_ctrl)) |-> $past(tx_done));

  // R10: flags stay set until a control write
  a_r10_rx_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[0] && !wr_ctrl) |=> ctrl_q[0]);
  a_r10_tx_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[1] && !wr_ctrl) |=> ctrl_q[1]);

  // R1: an idle transmitter holds the line high
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd_out);

  // R8: address filtering in 9-bit modes only accepts frames with ninth bit 1
  a_r8_ninth_bit_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && ctrl_q[5] && ctrl_q[7]) |-> rx_bit9);

  // R6: mode 1 with recognition accepts only a valid stop bit
  a_r6_stop_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && ctrl_q[7:5] == 3'b011) |-> rx_stop);

  // R9: an idle receiver with receive disabled stays idle
  a_r9_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[4] && !rx_busy) |=> !rx_busy);

  // R4: mode 0 reception leaves the received ninth bit alone
  a_r4_m0_keeps_b9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_accept && ctrl_q[7:6] == 2'b00 && !wr_ctrl) |=> (ctrl_q[2] == $past(ctrl_q[2])));
endmodule

bind mp_serial_port mp_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .ctrl_q(ctrl_q),
  .tx_done(tx_done), .tx_busy(tx_busy), .txd_out(txd_out),
  .rx_accept(rx_accept), .rx_busy(rx_busy), .rx_bit9(rx_bit9), .rx_stop(rx_stop)
);

// File: tb/mp_serial_port_tb.sv
module mp_serial_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       m2_fast = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       rxd_in = 1'b1;
  logic       txd_out, sclk_out, tx_irq, rx_irq;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;
  bit mon_busy = 0;

  typedef struct {
    bit         m0;
    int         nbits;
    logic [10:0] bits;
    int         bitclk;
    int         req;
  } exp_t;
  exp_t exp_q[$];

  mp_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .m2_fast(m2_fast),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rxd_in(rxd_in), .txd_out(txd_out), .sclk_out(sclk_out),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      baud_tick = ~baud_tick;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [7:0] cw(input int m, input bit ae, input bit re, input bit tb9);
    return {2'(m), ae, re, tb9, 3'b000};
  endfunction

  function automatic logic [10:0] fr9(input logic [7:0] d, input logic b9);
    return {1'b1, b9, d, 1'b0};
  endfunction

  function automatic logic [10:0] fr8(input logic [7:0] d, input logic stopb);
    return {1'b0, stopb, d, 1'b0};
  endfunction

  // driver: queue the expected line image, then write the data buffer
  task automatic push_tx(input int m, input logic [7:0] d, input logic b9,
                         input int bclk, input int req);
    exp_t it;
    it.m0 = (m == 0);
    it.req = req;
    it.bitclk = bclk;
    if (m == 0) begin it.nbits = 8; it.bits = {3'b000, d}; end
    else if (m >= 2) begin it.nbits = 11; it.bits = fr9(d, b9); end
    else begin it.nbits = 10; it.bits = fr8(d, 1'b1); end
    exp_q.push_back(it);
    wr(2'd1, d);
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
  endtask

  // monitor: decode txd_out and compare against the queued item
  initial begin
    exp_t it;
    logic [10:0] got;
    forever begin
      while (exp_q.size() == 0) @(negedge clk);
      mon_busy = 1;
      it = exp_q.pop_front();
      got = '0;
      if (it.m0) begin
        for (int i = 0; i < 8; i++) begin
          do @(negedge clk); while (sclk_out !== 1'b0);
          do @(negedge clk); while (sclk_out !== 1'b1);
          got[i] = txd_out;
          if (i == 7) chk($sformatf("R%0d tx flag before last shift", it.req), 16'(tx_irq), 16'h0);
        end
        repeat (6) @(negedge clk);
        chk($sformatf("R%0d tx flag after 8th bit", it.req), 16'(tx_irq), 16'h1);
      end else begin
        do @(negedge clk); while (txd_out !== 1'b0);
        repeat (it.bitclk / 2) @(negedge clk);
        for (int i = 0; i < it.nbits; i++) begin
          got[i] = txd_out;
          if (i == it.nbits - 2)
            chk($sformatf("R%0d tx flag at last data bit", it.req), 16'(tx_irq), 16'h0);
          if (i == it.nbits - 1)
            chk($sformatf("R%0d tx flag at stop bit", it.req), 16'(tx_irq), 16'h1);
          if (i != it.nbits - 1) repeat (it.bitclk) @(negedge clk);
        end
        repeat (it.bitclk) @(negedge clk);
      end
      chk($sformatf("R%0d tx frame bits", it.req), 16'(got), 16'(it.bits));
      mon_busy = 0;
    end
  end

  task automatic send_frame(input int nb, input logic [10:0] bits, input int bclk);
    for (int i = 0; i < nb; i++) begin
      rxd_in = bits[i];
      repeat (bclk) @(negedge clk);
    end
    rxd_in = 1'b1;
    repeat (bclk) @(negedge clk);
  endtask

  task automatic expect_rx(input string tag, input logic [7:0] ctrl_e, input logic [7:0] buf_e);
    logic [7:0] v;
    rd(2'd0, v);
    chk({tag, " ctrl"}, 16'(v), 16'(ctrl_e));
    rd(2'd1, v);
    chk({tag, " buffer"}, 16'(v), 16'(buf_e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_sim();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk("R1 register reset", 16'(v), 16'h0);
    end
    chk("R1 txd idle", 16'(txd_out), 16'h1);
    chk("R1 sclk idle", 16'(sclk_out), 16'h1);
    chk("R1 irqs low", 16'({tx_irq, rx_irq}), 16'h0);

    // R2 register readback
    wr(2'd2, 8'hA5); rd(2'd2, v); chk("R2 own address", 16'(v), 16'hA5);
    wr(2'd3, 8'h3C); rd(2'd3, v); chk("R2 mask", 16'(v), 16'h3C);
    wr(2'd0, 8'h6C); rd(2'd0, v); chk("R2 control", 16'(v), 16'h6C);

    // R4 mode 0 transmit
    wr(2'd0, 8'h00);
    push_tx(0, 8'h96, 1'b0, 4, 4);

    // R4 mode 0 receive, received ninth bit preset to 1 must survive
    wr(2'd0, 8'h14);
    for (int i = 0; i < 8; i++) begin
      do @(negedge clk); while (sclk_out !== 1'b0);
      rxd_in = v[0] ^ v[0] ^ ((8'h3B >> i) & 8'h01) != 0;
      do @(negedge clk); while (sclk_out !== 1'b1);
    end
    rxd_in = 1'b1;
    repeat (10) @(negedge clk);
    expect_rx("R4 mode0 rx", 8'h15, 8'h3B);

    // R9 receive disabled
    wr(2'd0, cw(1, 0, 0, 0));
    send_frame(10, fr8(8'hC3, 1'b1), 32);
    expect_rx("R9 disabled", 8'h40, 8'h3B);

    // R6 mode 1 receive, ninth-bit field takes the stop bit
    wr(2'd0, cw(1, 0, 1, 0));
    send_frame(10, fr8(8'hC3, 1'b1), 32);
    expect_rx("R6 mode1 rx", 8'h55, 8'hC3);

    // R10 flag stays set, cleared by software write
    repeat (50) @(negedge clk);
    chk("R10 rx flag held", 16'(rx_irq), 16'h1);
    wr(2'd0, cw(1, 0, 1, 0));
    chk("R10 rx flag cleared", 16'(rx_irq), 16'h0);

    // R6 stop bit 0 without recognition: accepted, field = 0
    send_frame(10, fr8(8'h11, 1'b0), 32);
    expect_rx("R6 stop0 accepted", 8'h51, 8'h11);

    // R6 with recognition: bad stop rejected, good stop accepted
    wr(2'd0, cw(1, 1, 1, 0));
    send_frame(10, fr8(8'h22, 1'b0), 32);
    expect_rx("R6 bad stop rejected", 8'h70, 8'h11);
    send_frame(10, fr8(8'h33, 1'b1), 32);
    expect_rx("R6 good stop accepted", 8'h75, 8'h33);

    // R11 short low glitch is not a start bit
    wr(2'd0, cw(1, 0, 1, 0));
    rxd_in = 1'b0;
    repeat (4) @(negedge clk);
    rxd_in = 1'b1;
    repeat (64) @(negedge clk);
    expect_rx("R11 false start", 8'h50, 8'h33);

    // R5 mode 1 transmit; R3 read returns receive buffer
    wr(2'd0, cw(1, 0, 0, 0));
    push_tx(1, 8'h5A, 1'b0, 32, 5);
    rd(2'd1, v);
    chk("R3 read returns rx buffer", 16'(v), 16'h33);

    // R7 mode 3 transmit with ninth bit 1
    wr(2'd0, cw(3, 0, 0, 1));
    push_tx(3, 8'h33, 1'b1, 32, 7);

    // R7 mode 3 receive of ninth bit
    wr(2'd0, cw(3, 0, 1, 0));
    send_frame(11, fr9(8'h81, 1'b0), 32);
    expect_rx("R7 mode3 b9=0", 8'hD1, 8'h81);
    wr(2'd0, cw(3, 0, 1, 0));
    send_frame(11, fr9(8'h7E, 1'b1), 32);
    expect_rx("R7 mode3 b9=1", 8'hD5, 8'h7E);

    // R7 mode 2 rates
    m2_fast = 1'b0;
    wr(2'd0, cw(2, 0, 0, 0));
    push_tx(2, 8'hA7, 1'b0, 32, 7);
    m2_fast = 1'b1;
    wr(2'd0, cw(2, 0, 0, 1));
    push_tx(2, 8'h3C, 1'b1, 16, 7);

    // R8 address filtering: own 0x12, mask 0xF0 (given 0x10, broadcast 0xF2)
    wr(2'd2, 8'h12);
    wr(2'd3, 8'hF0);
    wr(2'd0, cw(3, 1, 1, 0));
    send_frame(11, fr9(8'h1F, 1'b1), 32);
    expect_rx("R8 given match", 8'hF5, 8'h1F);
    wr(2'd0, cw(3, 1, 1, 0));
    send_frame(11, fr9(8'h20, 1'b1), 32);
    expect_rx("R8 mismatch", 8'hF0, 8'h1F);
    send_frame(11, fr9(8'hF7, 1'b1), 32);
    expect_rx("R8 broadcast match", 8'hF5, 8'hF7);
    wr(2'd0, cw(3, 1, 1, 0));
    send_frame(11, fr9(8'h1F, 1'b0), 32);
    expect_rx("R8 ninth bit 0 ignored", 8'hF0, 8'hF7);
    wr(2'd3, 8'h00);
    send_frame(11, fr9(8'h77, 1'b1), 32);
    expect_rx("R8 zero mask matches all", 8'hF5, 8'h77);
    wr(2'd0, cw(3, 0, 1, 0));
    send_frame(11, fr9(8'h44, 1'b0), 32);
    expect_rx("R8 recognition off", 8'hD1, 8'h44);

    finish_sim();
  end
endmodule